// File: doc/BRIEF.md
# Boot-Block Top-Swap Address Inverter

This block sits between the processor's fetch address and the boot ROM. It supports fault-tolerant rewrites of the boot block. While a swap control bit is set, every access that falls in the highest 16 MB of the 32-bit address space has one upper address line inverted. The reset-vector fetch is then served from a backup copy of the boot block instead of the primary one. A 3-bit size strap chooses which line is inverted, from A16 up to A20. The strap has to match the boot-block size.

The swap bit is kept in the real-time-clock power domain. An ordinary platform reset leaves it alone, and only the separate RTC-domain reset clears it. A lock bit is kept in the platform domain. Software can set the lock bit but cannot clear it. Once it is set, the swap bit can no longer be written until the next platform reset. The address path is purely combinational, so it adds no latency to a fetch.

Top module: `boot_swap_xlate`

## Requirements
- R1: With swap set and strap 0, an address in the window 0xFF000000–0xFFFFFFFF has bit 16 inverted. For example, 0xFFFFFFF0 maps to 0xFFFEFFF0 and 0xFF000000 maps to 0xFF010000.
- R2: With swap set, strap values 0, 1, 2, 3 and 4 invert address bit 16, 17, 18, 19 and 20 respectively. No other bit changes.
- R3: Strap values 5, 6 and 7 behave like strap 0 and invert bit 16.
- R4: An address whose bits 31:24 are not all ones leaves the block unchanged, whatever the swap bit is.
- R5: With swap clear, addr_o equals addr_i for every address.
- R6: addr_o follows addr_i and the strap within the same cycle, with no register in the path.
- R7: On a clock edge where cfg_we_i is 1 and lock_o is 0, the swap bit takes the value of cfg_swap_i. swap_o shows the stored swap bit from the next cycle on.
- R8: A write with cfg_we_i=1 and cfg_lock_i=1 sets lock_o. Writing 0 to cfg_lock_i never clears it. While lock_o is 1, writes leave the swap bit unchanged.
- R9: Asserting rst_ni clears lock_o and leaves the swap bit unchanged.
- R10: Asserting rtc_rst_ni clears the swap bit. After both resets, swap_o and lock_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Platform reset, active low, asynchronous; clears the lock bit |
| rtc_rst_ni | input | 1 | RTC-domain reset, active low, asynchronous; clears the swap bit |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_swap_i | input | 1 | Swap value to store when the bit is unlocked |
| cfg_lock_i | input | 1 | Write 1 to set the lock bit |
| size_strap_i | input | 3 | Boot-block size strap; selects which address line is inverted |
| addr_i | input | 32 | Address from the processor |
| addr_o | output | 32 | Address sent on to the ROM |
| swap_o | output | 1 | Current swap state, readable by software |
| lock_o | output | 1 | Current lock state |

## Verification
The checker tests a set of properties on every cycle:
- Addresses outside the window, and all addresses while swap is clear, pass through unchanged.
- Inside the window with swap set, exactly one bit differs, and it lies within bits 20:16.
- The lock bit never falls once it is set, and the swap bit holds while the lock is set.
- An unlocked write lands on the next cycle.

Some behaviour cannot be expressed as a per-cycle property and is shown only by the bench scenarios. This covers the exact bit each strap value picks, the fallback for unused strap codes, and the reset vector mapping to 0xFFFEFFF0. It also covers the split between the two reset domains: the swap bit survives a platform reset, while the RTC reset clears it.

// File: rtl/boot_swap_pkg.sv
package boot_swap_pkg;
  typedef struct packed {
    logic swap;
    logic lock;
  } swap_state_t;
endpackage

// File: rtl/swap_line_sel.sv
module swap_line_sel #(
  parameter int ADDR_W    = 32,
  parameter int STRAP_W   = 3,
  parameter int LINE_BASE = 16,
  parameter int LINE_CNT  = 5
) (
  input  logic [STRAP_W-1:0] strap_i,
  output logic [ADDR_W-1:0]  mask_o
);
  logic [LINE_CNT-1:0] hit;
  logic [LINE_CNT-1:0] onehot;

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_hit
    assign hit[g] = (strap_i == STRAP_W'(g));
  end

  // unused strap codes fall back to the lowest line
  assign onehot = (|hit) ? hit : LINE_CNT'(1);
  assign mask_o = ADDR_W'(onehot) << LINE_BASE;
endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import boot_swap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rtc_rst_ni,
  input  logic        we_i,
  input  logic        swap_i,
  input  logic        lock_i,
  output swap_state_t state_o
);
  logic swap_q, lock_q;

  // RTC domain: survives platform reset
  always_ff @(posedge clk_i or negedge rtc_rst_ni) begin
    if (!rtc_rst_ni)          swap_q <= 1'b0;
    else if (we_i && !lock_q) swap_q <= swap_i;
  end

  // platform domain, write-1-to-set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              lock_q <= 1'b0;
    else if (we_i && lock_i)  lock_q <= 1'b1;
  end

  assign state_o.swap = swap_q;
  assign state_o.lock = lock_q;
endmodule

// File: rtl/swap_addr_xlate.sv
module swap_addr_xlate #(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 8
) (
  input  logic              swap_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic in_win;
  assign in_win = &addr_i[ADDR_W-1 -: WIN_W];
  assign addr_o = (swap_i && in_win) ? (addr_i ^ mask_i) : addr_i;
endmodule

// File: rtl/boot_swap_xlate.sv
module boot_swap_xlate
  import boot_swap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STRAP_W   = 3,
  parameter int LINE_BASE = 16,
  parameter int LINE_CNT  = 5,
  parameter int WIN_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rtc_rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_swap_i,
  input  logic               cfg_lock_i,
  input  logic [STRAP_W-1:0] size_strap_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               swap_o,
  output logic               lock_o
);
  swap_state_t       st;
  logic [ADDR_W-1:0] mask;

  swap_ctrl u_ctrl (
    .clk_i, .rst_ni, .rtc_rst_ni,
    .we_i(cfg_we_i), .swap_i(cfg_swap_i), .lock_i(cfg_lock_i),
    .state_o(st)
  );

  swap_line_sel #(
    .ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .LINE_BASE(LINE_BASE), .LINE_CNT(LINE_CNT)
  ) u_sel (
    .strap_i(size_strap_i), .mask_o(mask)
  );

  swap_addr_xlate #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_xlate (
    .swap_i(st.swap), .mask_i(mask), .addr_i, .addr_o
  );

  assign swap_o = st.swap;
  assign lock_o = st.lock;
endmodule

// File: rtl/boot_swap_xlate_chk.sv
module boot_swap_xlate_chk #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BASE = 16,
  parameter int LINE_CNT  = 5,
  parameter int WIN_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rtc_rst_ni,
  input logic              cfg_we_i,
  input logic              cfg_swap_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              swap_o,
  input logic              lock_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(((1 << LINE_CNT) - 1) << LINE_BASE);
  logic in_win;
  assign in_win = &addr_i[ADDR_W-1 -: WIN_W];

  p_outside_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !rtc_rst_ni)
    !in_win |-> addr_o == addr_i);
  p_passthru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !rtc_rst_ni)
    !swap_o |-> addr_o == addr_i);
  p_one_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !rtc_rst_ni)
    (swap_o && in_win) |-> $countones(addr_o ^ addr_i) == 1);
  p_line_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !rtc_rst_ni)
    ((addr_o ^ addr_i) & ~LINE_MASK) == '0);
  p_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !rtc_rst_ni)
    (cfg_we_i && !lock_o) |=> swap_o == $past(cfg_swap_i));
  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !rtc_rst_ni)
    lock_o |=> lock_o);
  p_swap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !rtc_rst_ni)
    lock_o |=> $stable(swap_o));
endmodule

bind boot_swap_xlate boot_swap_xlate_chk #(
  .ADDR_W(ADDR_W), .LINE_BASE(LINE_BASE), .LINE_CNT(LINE_CNT), .WIN_W(WIN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rtc_rst_ni(rtc_rst_ni), .cfg_we_i(cfg_we_i),
  .cfg_swap_i(cfg_swap_i), .addr_i(addr_i), .addr_o(addr_o), .swap_o(swap_o),
  .lock_o(lock_o)
);

// File: tb/tb_boot_swap_xlate.sv
`timescale 1ns/1ps
module tb_boot_swap_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0, rtc_rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_swap_i = 1'b0, cfg_lock_i = 1'b0;
  logic [2:0]  size_strap_i = 3'd0;
  logic [31:0] addr_i = 32'h0, addr_o;
  logic        swap_o, lock_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  boot_swap_xlate dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit sw, bit lk);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_swap_i = sw; cfg_lock_i = lk;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_lock_i = 1'b0;
    #1;
  endtask

  task automatic xl(logic [2:0] s, logic [31:0] a);
    @(negedge clk_i);
    size_strap_i = s; addr_i = a;
    #1;
  endtask

  task automatic t_reset_r10();
    chk("R10 swap after reset", 32'(swap_o), 32'd0);
    chk("R10 lock after reset", 32'(lock_o), 32'd0);
    xl(3'd0, 32'hFFFF_FFF0);
    chk("R5 pass with swap clear", addr_o, 32'hFFFF_FFF0);
  endtask

  task automatic t_window_r1();
    wr(1'b1, 1'b0);
    chk("R7 swap written", 32'(swap_o), 32'd1);
    xl(3'd0, 32'hFFFF_FFF0);
    chk("R1 reset vector", addr_o, 32'hFFFE_FFF0);
    xl(3'd0, 32'hFF00_0000);
    chk("R1 window bottom", addr_o, 32'hFF01_0000);
    addr_i = 32'hFFFE_1234; #1;
    chk("R6 same-cycle response", addr_o, 32'hFFFF_1234);
  endtask

  task automatic t_strap_r2();
    for (int s = 0; s < 5; s++) begin
      xl(3'(s), 32'hFFFF_FFF0);
      chk("R2 strap line", addr_o, 32'hFFFF_FFF0 ^ (32'h1 << (16 + s)));
    end
  endtask

  task automatic t_strap_r3();
    for (int s = 5; s < 8; s++) begin
      xl(3'(s), 32'hFFFF_FFF0);
      chk("R3 unused strap", addr_o, 32'hFFFE_FFF0);
    end
  endtask

  task automatic t_outside_r4();
    xl(3'd0, 32'hFEFF_FFF0);
    chk("R4 below window", addr_o, 32'hFEFF_FFF0);
    xl(3'd2, 32'h0001_0000);
    chk("R4 low memory", addr_o, 32'h0001_0000);
  endtask

  task automatic t_lock_r8();
    wr(1'b1, 1'b1);
    chk("R8 lock set", 32'(lock_o), 32'd1);
    wr(1'b0, 1'b0);
    chk("R8 swap held while locked", 32'(swap_o), 32'd1);
    chk("R8 lock not cleared by write", 32'(lock_o), 32'd1);
    xl(3'd0, 32'hFFFF_FFF0);
    chk("R8 swap still active", addr_o, 32'hFFFE_FFF0);
  endtask

  task automatic t_plat_reset_r9();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk("R9 lock cleared", 32'(lock_o), 32'd0);
    chk("R9 swap kept", 32'(swap_o), 32'd1);
    xl(3'd0, 32'hFFFF_FFF0);
    chk("R9 swap still active", addr_o, 32'hFFFE_FFF0);
    wr(1'b0, 1'b0);
    chk("R7 unlocked write clears swap", 32'(swap_o), 32'd0);
    wr(1'b1, 1'b0);
  endtask

  task automatic t_rtc_reset_r10();
    @(negedge clk_i); rtc_rst_ni = 1'b0;
    @(negedge clk_i); rtc_rst_ni = 1'b1; #1;
    chk("R10 swap cleared by rtc reset", 32'(swap_o), 32'd0);
    xl(3'd1, 32'hFFFF_FFF0);
    chk("R5 pass after rtc reset", addr_o, 32'hFFFF_FFF0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1; rtc_rst_ni = 1'b1;
    #1;
    t_reset_r10();
    t_window_r1();
    t_strap_r2();
    t_strap_r3();
    t_outside_r4();
    t_lock_r8();
    t_plat_reset_r9();
    t_rtc_reset_r10();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule